// File: doc/BRIEF.md
# I/O Page-Table Address Translator

This block sits on the inbound DMA path of a PCI-to-system bridge. Each device address presented on its request port is reduced to a 4 KB page. The page is compared against a programmable window made of a base register and a mask register. If the window is disabled, or the page lies outside it, the page address is returned unchanged with read/write permission. If the page lies inside the window, the block reads one 64-bit entry from an in-memory page directory. The entry's top bit marks it valid. A valid entry supplies the translated page frame. An invalid entry produces a fault with no permission.

The block takes one translation at a time. A small control/status register file holds five 64-bit registers: the window base, the window mask, a purge command word, a configuration word and the directory base. The register file is visible at two aliased offsets. A five-state machine sequences each translation:

- IDLE accepts a request and moves to CHECK.
- CHECK evaluates the window. It moves to RESP on a pass-through, or to FETCH on a hit.
- FETCH holds the directory read until the memory accepts it, then moves to WAIT.
- WAIT holds until the entry returns, then moves to RESP.
- RESP presents the result for one cycle and returns to IDLE.

Top module: `iopt_xlate`

## Requirements
- R1: After reset, all five registers read zero. req_ready is 1, and resp_valid and mem_rd_valid are 0.
- R2: The registers are selected by csr_addr, and a register read returns its value in the same cycle. The five registers sit at offsets 0x20300 + 8*k, with k = 0 base, 1 mask, 2 purge, 3 config and 4 directory base. Each register is also reachable at 0x22300 + 8*k, which selects the same storage, so a write at either offset reads back at the other.
- R3: A write to any other csr_addr, including an address that is not a multiple of 8, changes no register. A read of such an address returns 0.
- R4: If bit 0 of base is 0, the response has resp_addr equal to req_addr with bits 11:0 cleared, resp_perm = 2'b11 (read-write) and resp_mask = 0xfff. No memory read is issued.
- R5: If bit 0 of base is 1 and (page & mask) differs from base with bit 0 cleared, the response is the same pass-through as in R4, with no memory read. Here page is req_addr with bits 11:0 cleared.
- R6: If bit 0 of base is 1 and (page & mask) equals base with bit 0 cleared, exactly one memory read is issued, at address dirbase + (page >> 12) * 8. mem_rd_valid and mem_rd_addr stay steady until mem_rd_ready is 1.
- R7: If the returned entry has bit 63 set, resp_addr is the entry with bit 63 and bits 11:0 cleared, and resp_perm = 2'b11.
- R8: If the returned entry has bit 63 clear, resp_perm = 2'b00 (no access) and resp_addr = 0.
- R9: Only one translation is in flight at a time. req_ready is 0 from the cycle after acceptance until the response has been given. resp_valid is high for exactly one cycle. On a pass-through, resp_valid is seen in the second cycle after the accepting edge.
- R10: Reading the purge register returns its last written value and starts no memory read and no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_wr | input | 1 | Register write strobe |
| csr_addr | input | 18 | Register byte offset |
| csr_wdata | input | 64 | Register write data |
| csr_rdata | output | 64 | Register read data (same cycle) |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Translator idle, request accepted at this edge |
| req_addr | input | 64 | Inbound device address |
| resp_valid | output | 1 | Translation result valid (one cycle) |
| resp_addr | output | 64 | Translated or passed-through page address |
| resp_mask | output | 12 | Page offset mask, always 0xfff |
| resp_perm | output | 2 | 2'b11 read-write, 2'b00 no access |
| mem_rd_valid | output | 1 | Directory entry read request |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | 64 | Directory entry byte address |
| mem_rsp_valid | input | 1 | Entry data returned |
| mem_rsp_data | input | 64 | Directory entry, little-endian 64-bit word |

## Verification
The assertions check the following on every cycle:
- the response is a single-cycle pulse;
- the request port stays closed while a translation is in flight;
- a stalled directory read keeps its address;
- every response is page aligned and carries a legal permission code;
- a fault always carries a zero address.

Only the bench scenarios can show whether the window decision, the entry address arithmetic and the frame extraction are correct. The bench sweeps pages across the window edges, with the window disabled, partly masked and fully open. It compares each response and each directory read address against values it computes itself. It also shows the register aliasing, the ignored offsets and the side-effect-free purge read.

// File: rtl/iopt_pkg.sv
package iopt_pkg;
    localparam int PAGE_SHIFT = 12;
    localparam int DW         = 64;
    localparam int NREG       = 5;

    localparam int REG_BASE  = 0;
    localparam int REG_MASK  = 1;
    localparam int REG_PURGE = 2;
    localparam int REG_CFG   = 3;
    localparam int REG_DIR   = 4;

    localparam logic [1:0] PERM_NONE = 2'b00;
    localparam logic [1:0] PERM_RW   = 2'b11;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_FETCH,
        ST_WAIT,
        ST_RESP
    } xl_state_e;
endpackage

// File: rtl/iopt_csr.sv
module iopt_csr #(
    parameter int CSR_AW = 18,
    parameter int NALIAS = 2,
    parameter logic [NALIAS-1:0][CSR_AW-1:0] BLK_OFS = {18'h22300, 18'h20300}
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   csr_wr,
    input  logic [CSR_AW-1:0]      csr_addr,
    input  logic [iopt_pkg::DW-1:0] csr_wdata,
    output logic [iopt_pkg::DW-1:0] csr_rdata,
    output logic [iopt_pkg::DW-1:0] base_o,
    output logic [iopt_pkg::DW-1:0] mask_o,
    output logic [iopt_pkg::DW-1:0] dir_o
);
    import iopt_pkg::*;

    localparam int IW = $clog2(NREG);
    localparam logic [CSR_AW-1:0] SPAN = CSR_AW'(NREG * 8);

    logic [DW-1:0]        regs_q [NREG];
    logic [NALIAS-1:0]    alias_hit;
    logic [CSR_AW-1:0]    alias_off [NALIAS];
    logic                 dec_hit;
    logic [IW-1:0]        dec_idx;

    for (genvar g = 0; g < NALIAS; g++) begin : g_alias
        assign alias_off[g] = csr_addr - BLK_OFS[g];
        assign alias_hit[g] = (alias_off[g] < SPAN) && (alias_off[g][2:0] == 3'b000);
    end

    always_comb begin
        dec_hit = 1'b0;
        dec_idx = '0;
        for (int a = 0; a < NALIAS; a++) begin
            if (alias_hit[a] && !dec_hit) begin
                dec_hit = 1'b1;
                dec_idx = alias_off[a][IW+2:3];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < NREG; r++) regs_q[r] <= '0;
        end else if (csr_wr && dec_hit) begin
            for (int r = 0; r < NREG; r++) begin
                if (dec_idx == IW'(r)) regs_q[r] <= csr_wdata;
            end
        end
    end

    always_comb begin
        csr_rdata = '0;
        for (int r = 0; r < NREG; r++) begin
            if (dec_hit && dec_idx == IW'(r)) csr_rdata = regs_q[r];
        end
    end

    assign base_o = regs_q[REG_BASE];
    assign mask_o = regs_q[REG_MASK];
    assign dir_o  = regs_q[REG_DIR];
endmodule

// File: rtl/iopt_window.sv
module iopt_window (
    input  logic [iopt_pkg::DW-1:0] page_addr,
    input  logic [iopt_pkg::DW-1:0] base,
    input  logic [iopt_pkg::DW-1:0] mask,
    input  logic [iopt_pkg::DW-1:0] dirbase,
    output logic                    win_hit,
    output logic [iopt_pkg::DW-1:0] pte_addr
);
    import iopt_pkg::*;

    logic          range_en;
    logic [DW-1:0] base_cmp;

    assign range_en = base[0];
    assign base_cmp = {base[DW-1:1], 1'b0};
    assign win_hit  = range_en && ((page_addr & mask) == base_cmp);
    assign pte_addr = dirbase + ((page_addr >> PAGE_SHIFT) << 3);
endmodule

// File: rtl/iopt_fsm.sv
module iopt_fsm (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [iopt_pkg::DW-1:0] req_addr,
    output logic [iopt_pkg::DW-1:0] page_q,
    input  logic                    win_hit,
    input  logic [iopt_pkg::DW-1:0] pte_addr,
    output logic                    mem_rd_valid,
    input  logic                    mem_rd_ready,
    output logic [iopt_pkg::DW-1:0] mem_rd_addr,
    input  logic                    mem_rsp_valid,
    input  logic [iopt_pkg::DW-1:0] mem_rsp_data,
    output logic                    resp_valid,
    output logic [iopt_pkg::DW-1:0] resp_addr,
    output logic [1:0]              resp_perm
);
    import iopt_pkg::*;

    localparam logic [DW-1:0] OFF_MASK = DW'((64'd1 << PAGE_SHIFT) - 64'd1);
    localparam logic [DW-1:0] VLD_BIT  = DW'(64'd1) << (DW - 1);

    xl_state_e state_q, state_d;
    logic [DW-1:0] fetch_q;
    logic [DW-1:0] res_addr_q;
    logic [1:0]    res_perm_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid)     state_d = ST_CHECK;
            ST_CHECK: state_d = win_hit ? ST_FETCH : ST_RESP;
            ST_FETCH: if (mem_rd_ready)  state_d = ST_WAIT;
            ST_WAIT:  if (mem_rsp_valid) state_d = ST_RESP;
            ST_RESP:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q     <= '0;
            fetch_q    <= '0;
            res_addr_q <= '0;
            res_perm_q <= PERM_NONE;
        end else begin
            unique case (state_q)
                ST_IDLE: if (req_valid) page_q <= req_addr & ~OFF_MASK;
                ST_CHECK: begin
                    if (win_hit) begin
                        fetch_q <= pte_addr;
                    end else begin
                        res_addr_q <= page_q;
                        res_perm_q <= PERM_RW;
                    end
                end
                ST_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (mem_rsp_data[DW-1]) begin
                            res_addr_q <= mem_rsp_data & ~VLD_BIT & ~OFF_MASK;
                            res_perm_q <= PERM_RW;
                        end else begin
                            res_addr_q <= '0;
                            res_perm_q <= PERM_NONE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign req_ready    = (state_q == ST_IDLE);
    assign mem_rd_valid = (state_q == ST_FETCH);
    assign mem_rd_addr  = fetch_q;
    assign resp_valid   = (state_q == ST_RESP);
    assign resp_addr    = res_addr_q;
    assign resp_perm    = res_perm_q;
endmodule

// File: rtl/iopt_xlate.sv
module iopt_xlate #(
    parameter int CSR_AW = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csr_wr,
    input  logic [CSR_AW-1:0] csr_addr,
    input  logic [63:0]       csr_wdata,
    output logic [63:0]       csr_rdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [63:0]       req_addr,
    output logic              resp_valid,
    output logic [63:0]       resp_addr,
    output logic [11:0]       resp_mask,
    output logic [1:0]        resp_perm,
    output logic              mem_rd_valid,
    input  logic              mem_rd_ready,
    output logic [63:0]       mem_rd_addr,
    input  logic              mem_rsp_valid,
    input  logic [63:0]       mem_rsp_data
);
    import iopt_pkg::*;

    logic [DW-1:0] base_w, mask_w, dir_w, page_w, pte_w;
    logic          hit_w;

    iopt_csr #(.CSR_AW(CSR_AW)) u_csr (
        .clk      (clk),
        .rst_n    (rst_n),
        .csr_wr   (csr_wr),
        .csr_addr (csr_addr),
        .csr_wdata(csr_wdata),
        .csr_rdata(csr_rdata),
        .base_o   (base_w),
        .mask_o   (mask_w),
        .dir_o    (dir_w)
    );

    iopt_window u_win (
        .page_addr(page_w),
        .base     (base_w),
        .mask     (mask_w),
        .dirbase  (dir_w),
        .win_hit  (hit_w),
        .pte_addr (pte_w)
    );

    iopt_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_addr     (req_addr),
        .page_q       (page_w),
        .win_hit      (hit_w),
        .pte_addr     (pte_w),
        .mem_rd_valid (mem_rd_valid),
        .mem_rd_ready (mem_rd_ready),
        .mem_rd_addr  (mem_rd_addr),
        .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data (mem_rsp_data),
        .resp_valid   (resp_valid),
        .resp_addr    (resp_addr),
        .resp_perm    (resp_perm)
    );

    assign resp_mask = 12'(( 64'd1 << PAGE_SHIFT) - 64'd1);
endmodule

// File: rtl/iopt_xlate_chk.sv
module iopt_xlate_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic        resp_valid,
    input logic [63:0] resp_addr,
    input logic [11:0] resp_mask,
    input logic [1:0]  resp_perm,
    input logic        mem_rd_valid,
    input logic        mem_rd_ready,
    input logic [63:0] mem_rd_addr
);
    a_r9_resp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    a_r9_single_flight: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    a_r9_resp_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> !req_ready);

    a_r6_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

    a_r8_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_perm == 2'b00) |-> (resp_addr == 64'd0));

    a_r4_page_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> (resp_addr[11:0] == 12'h000 && resp_mask == 12'hfff));

    a_r7_perm_code: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> (resp_perm == 2'b00 || resp_perm == 2'b11));
endmodule

bind iopt_xlate iopt_xlate_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .resp_valid  (resp_valid),
    .resp_addr   (resp_addr),
    .resp_mask   (resp_mask),
    .resp_perm   (resp_perm),
    .mem_rd_valid(mem_rd_valid),
    .mem_rd_ready(mem_rd_ready),
    .mem_rd_addr (mem_rd_addr)
);

// File: tb/sim_iopt_xlate.sv
`timescale 1ns/1ps
module sim_iopt_xlate;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_wr = 1'b0;
    logic [17:0] csr_addr = '0;
    logic [63:0] csr_wdata = '0;
    logic [63:0] csr_rdata;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_addr = '0;
    logic        resp_valid;
    logic [63:0] resp_addr;
    logic [11:0] resp_mask;
    logic [1:0]  resp_perm;
    logic        mem_rd_valid;
    logic        mem_rd_ready = 1'b0;
    logic [63:0] mem_rd_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    iopt_xlate u0 (.*);

    // memory model: ready toggles, entry returned a few cycles after acceptance
    logic [3:0]  stall_ctr = '0;
    logic        pend = 1'b0;
    logic [1:0]  dly = '0;
    logic [63:0] paddr = '0;
    int          fetch_cnt = 0;
    logic [63:0] last_fetch = '0;

    function automatic logic [63:0] pte_of(input logic [63:0] a);
        return {^a[6:3], 11'h000, a[39:0] ^ 40'h5A_5A5A_5A5A, 12'h3C5};
    endfunction

    always @(posedge clk) begin
        cycles <= cycles + 1;
        stall_ctr <= stall_ctr + 4'd1;
        mem_rd_ready <= stall_ctr[1];
        mem_rsp_valid <= 1'b0;
        if (pend) begin
            if (dly == 2'd0) begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_data  <= pte_of(paddr);
                pend <= 1'b0;
            end else begin
                dly <= dly - 2'd1;
            end
        end else if (mem_rd_valid && mem_rd_ready) begin
            pend <= 1'b1;
            paddr <= mem_rd_addr;
            dly <= 2'd2;
            fetch_cnt <= fetch_cnt + 1;
            last_fetch <= mem_rd_addr;
        end
        if (cycles > WATCHDOG && !done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=%0d cycles expected<%0d", cycles, WATCHDOG);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic csr_write(input logic [17:0] a, input logic [63:0] d);
        @(negedge clk);
        csr_wr = 1'b1; csr_addr = a; csr_wdata = d;
        @(negedge clk);
        csr_wr = 1'b0;
    endtask

    task automatic csr_read(input logic [17:0] a, output logic [63:0] d);
        @(negedge clk);
        csr_addr = a;
        #1;
        d = csr_rdata;
    endtask

    task automatic xlate(input logic [63:0] a, output logic [63:0] ra,
                         output logic [1:0] rp, output logic [11:0] rm, output int lat);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!resp_valid && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        ra = resp_addr; rp = resp_perm; rm = resp_mask;
    endtask

    // one translation with bench-computed expectations
    task automatic run_one(input logic [63:0] a, input logic [63:0] base,
                           input logic [63:0] mask, input logic [63:0] dir, input string tag);
        logic [63:0] page, fa, ent, exp_a, ra;
        logic [1:0]  exp_p, rp;
        logic [11:0] rm;
        bit          hit;
        int          lat, f0;
        page = a & ~64'hfff;
        hit = base[0] && ((page & mask) == {base[63:1], 1'b0});
        fa = dir + (page >> 12) * 64'd8;
        exp_a = page; exp_p = 2'b11;
        if (hit) begin
            ent = pte_of(fa);
            if (ent[63]) begin
                exp_a = ent & 64'h7FFF_FFFF_FFFF_F000; exp_p = 2'b11;
            end else begin
                exp_a = 64'd0; exp_p = 2'b00;
            end
        end
        f0 = fetch_cnt;
        xlate(a, ra, rp, rm, lat);
        check(ra == exp_a, {tag, " resp_addr"}, ra, exp_a);
        check(rp == exp_p, {tag, " resp_perm R7 R8"}, 64'(rp), 64'(exp_p));
        check(rm == 12'hfff, "R4 resp_mask", 64'(rm), 64'hfff);
        if (hit) begin
            check(fetch_cnt - f0 == 1, "R6 one read", 64'(fetch_cnt - f0), 64'd1);
            check(last_fetch == fa, "R6 entry address", last_fetch, fa);
        end else begin
            check(fetch_cnt == f0, {tag, " no read"}, 64'(fetch_cnt - f0), 64'd0);
            check(lat == 2, "R9 pass-through latency", 64'(lat), 64'd2);
        end
        @(negedge clk);
        check(!resp_valid, "R9 single pulse", 64'(resp_valid), 64'd0);
    endtask

    initial begin
        logic [63:0] rd;
        logic [63:0] pat [5];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check(req_ready == 1'b1, "R1 req_ready", 64'(req_ready), 64'd1);
        check(resp_valid == 1'b0, "R1 resp_valid", 64'(resp_valid), 64'd0);
        check(mem_rd_valid == 1'b0, "R1 mem_rd_valid", 64'(mem_rd_valid), 64'd0);
        for (int k = 0; k < 5; k++) begin
            csr_read(18'h20300 + 18'(8 * k), rd);
            check(rd == 64'd0, "R1 reg zero", rd, 64'd0);
            csr_read(18'h22300 + 18'(8 * k), rd);
            check(rd == 64'd0, "R1 alias zero", rd, 64'd0);
        end

        // R2: write primary, read alias
        for (int k = 0; k < 5; k++) begin
            pat[k] = 64'hA5A5_0000_0000_0000 ^ (64'(k + 1) * 64'h1111_2222_3333);
            csr_write(18'h20300 + 18'(8 * k), pat[k]);
        end
        for (int k = 0; k < 5; k++) begin
            csr_read(18'h22300 + 18'(8 * k), rd);
            check(rd == pat[k], "R2 alias read", rd, pat[k]);
        end
        csr_write(18'h22318, 64'hDEAD_BEEF_0BAD_F00D);
        pat[3] = 64'hDEAD_BEEF_0BAD_F00D;
        csr_read(18'h20318, rd);
        check(rd == pat[3], "R2 alias write", rd, pat[3]);

        // R3: unmapped offsets ignored
        csr_write(18'h20328, 64'h1);
        csr_write(18'h20304, 64'h2);
        csr_write(18'h21300, 64'h3);
        csr_write(18'h202F8, 64'h4);
        csr_read(18'h20328, rd); check(rd == 64'd0, "R3 read 0x20328", rd, 64'd0);
        csr_read(18'h20304, rd); check(rd == 64'd0, "R3 read 0x20304", rd, 64'd0);
        csr_read(18'h21300, rd); check(rd == 64'd0, "R3 read 0x21300", rd, 64'd0);
        for (int k = 0; k < 5; k++) begin
            csr_read(18'h20300 + 18'(8 * k), rd);
            check(rd == pat[k], "R3 regs unchanged", rd, pat[k]);
        end

        // R10: purge read has no side effect
        csr_write(18'h20310, 64'h0000_0000_CAFE_0001);
        for (int k = 0; k < 3; k++) begin
            csr_read(18'h20310, rd);
            check(rd == 64'h0000_0000_CAFE_0001, "R10 purge readback", rd, 64'h0000_0000_CAFE_0001);
            check(!mem_rd_valid && !resp_valid && req_ready, "R10 no activity",
                  64'({mem_rd_valid, resp_valid, req_ready}), 64'b001);
        end

        // R4: window disabled
        csr_write(18'h20300, 64'h0000_0000_0012_0000);
        csr_write(18'h20308, 64'h0000_0000_FFFF_0000);
        csr_write(18'h20320, 64'h0000_0000_8000_0000);
        for (int i = 0; i < 8; i++)
            run_one(64'h0012_0000 + 64'(i) * 64'h1000 + 64'(i * 37), 64'h0012_0000,
                    64'hFFFF_0000, 64'h8000_0000, "R4");

        // R5, R6, R7, R8: enabled window, sweep across both edges
        csr_write(18'h20300, 64'h0000_0000_0012_0001);
        for (int i = 0; i < 32; i++)
            run_one(64'h0011_F000 + 64'(i) * 64'h1000 + 64'(i * 55), 64'h0012_0001,
                    64'hFFFF_0000, 64'h8000_0000, "R5 R6");

        // fully open window: every page hits, alias-programmed directory base
        csr_write(18'h22300, 64'h1);
        csr_write(18'h22308, 64'h0);
        csr_write(18'h22320, 64'h0000_0040_0000_0008);
        for (int i = 0; i < 12; i++)
            run_one(64'hFFFF_F000_0000_0000 + 64'(i) * 64'h0000_0001_0000_1000 + 64'(i),
                    64'h1, 64'h0, 64'h0000_0040_0000_0008, "R6 open");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule